// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block orders the start-up of a multiphase regulator controller. It watches a supply-good flag from an undervoltage comparator and an enable pin. While either is low, it holds the current-sense reference node grounded through a discharge switch. When both are high, it steps through a fixed order:

1. Turn on internal bias and wait out a timed reset window.
2. Ask for detection of the phase count and wait for the detect-done flag.
3. Issue the soft-start go and wait for the soft-start-done flag.
4. Wait for the active-low clock-enable strobe.
5. Open the VID latch and run a long internal power-good delay.
6. Raise power-good.

All timing is counted in clock cycles, derived from a clock-frequency parameter. The analog parts are seen only as input flags: the comparators, the soft-start ramp and phase detection.

Losing supply or enable at any point drops every output except the discharge switch in the same cycle. The sequencer returns to its idle state on the next edge, so a later start-up runs the full order again, timers included.

Top module: `pwrseq_top`

## Requirements
- R1: `discharge_o` is 1 whenever `supply_ok_i` or `en_i` is 0, and while the sequencer is idle. It is 0 in every other state while both inputs are 1.
- R2: `bias_en_o` rises at the first rising edge that samples `supply_ok_i` and `en_i` both high. `phase_req_o` rises at edge RST_CYC+1 counted from that edge, where RST_CYC = CLK_HZ*RESET_US/1e6 (55 µs by default). Nothing except bias is high during the reset window.
- R3: `phase_req_o` stays high, and `ss_go_o` stays low, until an edge samples `phase_done_i` high. From that edge on, `phase_req_o` is 0 and `ss_go_o` is 1. `ss_done_i` and `clken_n_i` have no effect before this point.
- R4: `clken_n_i` is ignored until an edge has sampled `ss_done_i` high. The first later edge that samples `clken_n_i` low accepts the strobe and raises `vid_latch_en_o`. `vid_o` holds its value until then. From the edge after acceptance, `vid_o` loads `vid_i` on every edge. Later values of `clken_n_i` are ignored.
- R5: `pgood_o` rises at edge PG_CYC+1 counted from the edge that accepts the strobe, where PG_CYC = CLK_HZ*PGOOD_US/1e6 (9 ms by default). `pgood_o` is 0 in every earlier state.
- R6: From any non-idle state, a low on `supply_ok_i` or `en_i` forces all outputs except `discharge_o` to 0 in the same cycle. The sequencer is idle from the next edge.
- R7: After an abort, a new start-up repeats the full reset window of R2.
- R8: While `rst_n` is low, `discharge_o` is 1, all other control outputs are 0, and `vid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| en_i | input | 1 | Enable pin |
| clken_n_i | input | 1 | Active-low clock-enable strobe |
| phase_done_i | input | 1 | Phase-count detection finished |
| ss_done_i | input | 1 | Soft-start ramp finished |
| vid_i | input | VID_W | Voltage identification code |
| bias_en_o | output | 1 | Internal bias enable |
| phase_req_o | output | 1 | Phase-count detection request |
| ss_go_o | output | 1 | Soft-start go |
| vid_latch_en_o | output | 1 | VID latch open |
| discharge_o | output | 1 | Ground the current-sense reference node |
| pgood_o | output | 1 | Power good |
| vid_o | output | VID_W | Latched VID code |

## Verification
The main sequence is driven with several kinds of input pattern:
- **Premature flags:** `ss_done_i` and `clken_n_i` are pulsed before their turn. Any transition taken out of order shows up as a change in the outputs.
- **Edge counts:** each timed window is counted edge by edge. A reset window or power-good delay that is one cycle long or short is reported.
- **VID changes:** `vid_i` changes before the strobe, at the strobe and after it. This separates a latch that opens early from one that opens late.
- **Abort sweep:** every reachable state is aborted once through enable and once through the supply flag. The outputs are checked in the abort cycle and after the next edge, and the restart timing is measured again.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RESET   = 3'd1,
    ST_PHASE   = 3'd2,
    ST_SOFT    = 3'd3,
    ST_WAITCLK = 3'd4,
    ST_PGDLY   = 3'd5,
    ST_RUN     = 3'd6
  } seq_state_e;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run_i ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (cnt_q == limit_i - CNT_W'(1));

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < limit_i)); // R2
endmodule

// File: rtl/pwrseq_vid.sv
module pwrseq_vid #(
  parameter int VID_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] vid_o
);
  logic [VID_W-1:0] vid_q, vid_d;

  always_comb begin
    vid_d = load_i ? vid_i : vid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vid_q <= '0;
    else        vid_q <= vid_d;
  end

  assign vid_o = vid_q;

  AST_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(vid_o)); // R4
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  input  logic phase_done_i,
  input  logic ss_done_i,
  input  logic clken_n_i,
  input  logic tmr_expire_i,
  output logic tmr_run_o,
  output logic tmr_sel_pg_o,
  output logic bias_en_o,
  output logic phase_req_o,
  output logic ss_go_o,
  output logic vid_latch_en_o,
  output logic discharge_o,
  output logic pgood_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!ok_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = ST_RESET;
        ST_RESET:   if (tmr_expire_i) state_d = ST_PHASE;
        ST_PHASE:   if (phase_done_i) state_d = ST_SOFT;
        ST_SOFT:    if (ss_done_i)    state_d = ST_WAITCLK;
        ST_WAITCLK: if (!clken_n_i)   state_d = ST_PGDLY;
        ST_PGDLY:   if (tmr_expire_i) state_d = ST_RUN;
        ST_RUN:     state_d = ST_RUN;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign tmr_run_o      = (state_q == ST_RESET) || (state_q == ST_PGDLY);
  assign tmr_sel_pg_o   = (state_q == ST_PGDLY);
  assign bias_en_o      = ok_i && (state_q != ST_OFF);
  assign phase_req_o    = ok_i && (state_q == ST_PHASE);
  assign ss_go_o        = ok_i && (state_q inside {ST_SOFT, ST_WAITCLK, ST_PGDLY, ST_RUN});
  assign vid_latch_en_o = ok_i && (state_q inside {ST_PGDLY, ST_RUN});
  assign discharge_o    = !ok_i || (state_q == ST_OFF);
  assign pgood_o        = ok_i && (state_q == ST_RUN);

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_i |=> (state_q == ST_OFF)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET) |-> (!pgood_o && !ss_go_o && !phase_req_o)); // R2
  AST_SS_AFTER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_go_o) |-> ($past(state_q) == ST_PHASE)); // R3
  AST_LATCH_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_latch_en_o) |-> (($past(state_q) == ST_WAITCLK) && !$past(clken_n_i))); // R4
  AST_PG_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> ($past(state_q) == ST_PGDLY)); // R5
  AST_LOSS_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_i |-> (discharge_o && !bias_en_o && !pgood_o)); // R1
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int RESET_US = 55,
  parameter int PGOOD_US = 9000,
  parameter int VID_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             en_i,
  input  logic             clken_n_i,
  input  logic             phase_done_i,
  input  logic             ss_done_i,
  input  logic [VID_W-1:0] vid_i,
  output logic             bias_en_o,
  output logic             phase_req_o,
  output logic             ss_go_o,
  output logic             vid_latch_en_o,
  output logic             discharge_o,
  output logic             pgood_o,
  output logic [VID_W-1:0] vid_o
);
  localparam longint RST_RAW = (longint'(CLK_HZ) * RESET_US) / 1_000_000;
  localparam longint PG_RAW  = (longint'(CLK_HZ) * PGOOD_US) / 1_000_000;
  localparam longint RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam longint PG_CYC  = (PG_RAW < 1) ? 1 : PG_RAW;
  localparam longint MAX_CYC = (RST_CYC > PG_CYC) ? RST_CYC : PG_CYC;
  localparam int     CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] PG_LIM  = CNT_W'(PG_CYC);

  logic ok;
  logic tmr_run, tmr_sel_pg, tmr_expire;
  logic [CNT_W-1:0] tmr_limit;

  assign ok        = supply_ok_i && en_i;
  assign tmr_limit = tmr_sel_pg ? PG_LIM : RST_LIM;

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (tmr_run),
    .limit_i  (tmr_limit),
    .expire_o (tmr_expire)
  );

  pwrseq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .ok_i           (ok),
    .phase_done_i   (phase_done_i),
    .ss_done_i      (ss_done_i),
    .clken_n_i      (clken_n_i),
    .tmr_expire_i   (tmr_expire),
    .tmr_run_o      (tmr_run),
    .tmr_sel_pg_o   (tmr_sel_pg),
    .bias_en_o      (bias_en_o),
    .phase_req_o    (phase_req_o),
    .ss_go_o        (ss_go_o),
    .vid_latch_en_o (vid_latch_en_o),
    .discharge_o    (discharge_o),
    .pgood_o        (pgood_o)
  );

  pwrseq_vid #(.VID_W(VID_W)) u_vid (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (vid_latch_en_o),
    .vid_i  (vid_i),
    .vid_o  (vid_o)
  );
endmodule

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
  localparam int CLK_HZ   = 50_000_000;
  localparam int RESET_US = 1;
  localparam int PGOOD_US = 4;
  localparam int VID_W    = 7;
  localparam int RST_CYC  = CLK_HZ / 1_000_000 * RESET_US;
  localparam int PG_CYC   = CLK_HZ / 1_000_000 * PGOOD_US;

  // {bias, phase_req, ss_go, vid_en, discharge, pgood}
  localparam logic [5:0] V_OFF = 6'b000010;
  localparam logic [5:0] V_RST = 6'b100000;
  localparam logic [5:0] V_PD  = 6'b110000;
  localparam logic [5:0] V_SS  = 6'b101000;
  localparam logic [5:0] V_PGD = 6'b101100;
  localparam logic [5:0] V_RUN = 6'b101101;

  logic clk, rst_n, supply_ok, en, clken_n, phase_done, ss_done;
  logic [VID_W-1:0] vid, vid_q;
  logic bias, phase_req, ss_go, vid_en, disch, pgood;
  int n_tests, n_fail;

  pwrseq_top #(.CLK_HZ(CLK_HZ), .RESET_US(RESET_US), .PGOOD_US(PGOOD_US), .VID_W(VID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .en_i(en), .clken_n_i(clken_n),
    .phase_done_i(phase_done), .ss_done_i(ss_done), .vid_i(vid),
    .bias_en_o(bias), .phase_req_o(phase_req), .ss_go_o(ss_go), .vid_latch_en_o(vid_en),
    .discharge_o(disch), .pgood_o(pgood), .vid_o(vid_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {bias, phase_req, ss_go, vid_en, disch, pgood};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_vid(input string req, input logic [VID_W-1:0] exp);
    n_tests++;
    if (vid_q !== exp) begin
      n_fail++;
      $display("FAIL %s vid act=%h exp=%h", req, vid_q, exp);
    end
  endtask

  function automatic logic [5:0] stage_vec(input int s);
    case (s)
      1: return V_RST;
      2: return V_PD;
      3: return V_SS;
      4: return V_SS;
      5: return V_PGD;
      6: return V_RUN;
      default: return V_OFF;
    endcase
  endfunction

  task automatic advance_to(input int s);
    supply_ok = 1'b1; en = 1'b1;
    tick();
    if (s >= 2) repeat (RST_CYC) tick();
    if (s >= 3) begin phase_done = 1'b1; tick(); phase_done = 1'b0; end
    if (s >= 4) begin ss_done = 1'b1; tick(); ss_done = 1'b0; end
    if (s >= 5) begin clken_n = 1'b0; tick(); clken_n = 1'b1; end
    if (s >= 6) repeat (PG_CYC) tick();
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; supply_ok = 1'b0; en = 1'b0; clken_n = 1'b1;
    phase_done = 1'b0; ss_done = 1'b0; vid = '0;
    repeat (3) @(negedge clk);
    chk("R8", V_OFF);
    chk_vid("R8", '0);
    rst_n = 1'b1;
    tick();

    // Full sequence with timing
    supply_ok = 1'b1; en = 1'b0;
    tick();
    chk("R1 enable low", V_OFF);
    en = 1'b1;
    tick();
    chk("R2 bias on", V_RST);
    repeat (RST_CYC - 1) tick();
    chk("R2 window end-1", V_RST);
    tick();
    chk("R2 phase request", V_PD);
    ss_done = 1'b1; clken_n = 1'b0; vid = 7'h55;
    repeat (3) tick();
    chk("R3 wait phase done", V_PD);
    chk_vid("R4 early", '0);
    ss_done = 1'b0; clken_n = 1'b1;
    phase_done = 1'b1; tick(); phase_done = 1'b0;
    chk("R3 soft start", V_SS);
    clken_n = 1'b0;
    repeat (3) tick();
    chk("R4 strobe before ss_done", V_SS);
    chk_vid("R4 strobe before ss_done", '0);
    clken_n = 1'b1;
    ss_done = 1'b1; tick(); ss_done = 1'b0;
    repeat (2) tick();
    chk("R4 waiting strobe", V_SS);
    vid = 7'h2A;
    clken_n = 1'b0; tick(); clken_n = 1'b1;
    chk("R4 strobe accepted", V_PGD);
    chk_vid("R4 accept edge", '0);
    vid = 7'h13;
    tick();
    chk_vid("R4 loads", 7'h13);
    repeat (PG_CYC - 2) tick();
    chk("R5 delay end-1", V_PGD);
    tick();
    chk("R5 power good", V_RUN);
    vid = 7'h6E; tick();
    chk_vid("R4 tracks in run", 7'h6E);
    supply_ok = 1'b0; #1;
    chk("R6 same cycle", V_OFF);
    tick();
    chk("R6 idle", V_OFF);
    tick();
    chk("R1 supply low", V_OFF);
    en = 1'b0; supply_ok = 1'b1; tick();

    // Abort sweep over every state, both abort causes
    for (int s = 1; s <= 6; s++) begin
      for (int way = 0; way < 2; way++) begin
        advance_to(s);
        chk($sformatf("R6 stage %0d reached", s), stage_vec(s));
        if (way == 0) en = 1'b0; else supply_ok = 1'b0;
        #1;
        chk($sformatf("R6 stage %0d way %0d comb", s, way), V_OFF);
        tick();
        chk($sformatf("R6 stage %0d way %0d idle", s, way), V_OFF);
        supply_ok = 1'b1; en = 1'b1;
        tick();
        chk("R7 restart bias", V_RST);
        repeat (RST_CYC - 1) tick();
        chk("R7 window end-1", V_RST);
        tick();
        chk("R7 phase request", V_PD);
        en = 1'b0; tick();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule